// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a parameterised number of peripheral inputs and from eight software-raised sources. Each source holds a programmable 4-bit priority. A pipelined arbiter picks the highest-priority pending request. The single interrupt line to the processor is raised only when that winner's priority is strictly above the processor's current-priority register. Every source has a fixed 9-bit vector. Software source k uses vector k, and peripheral input n uses vector 8 + n.

The vector of the latest preempting winner is held in an acknowledge register, which can be read over the register bus. When hardware vector mode is on, the same vector is also driven on a dedicated vector output. Software raises a request by writing a 1 to its SET bit and lowers it by writing a 1 to its CLR bit. Peripheral requests are level inputs and are not latched inside the block.

Top module: `vpic_top`

## Requirements
- R1: A peripheral request is level-sensitive. The interrupt output rises exactly three clock edges after the input is first sampled high. It falls three edges after the input drops, with no latching.
- R2: A register write that sets a software flag raises the interrupt output exactly four clock edges after the write edge.
- R3: Writing word 0 with bit k of [7:0] set sets software flag k, and bit k of [15:8] set clears it. When both are 1 in one write, the flag ends cleared. Zero bits leave flags unchanged. Flags read back in word 0 bits [7:0].
- R4: Vectors are fixed: software source k is vector k, and peripheral input n is vector 8 + n. The latest preempting vector reads back in word 3 bits [8:0].
- R5: Among pending requests, the highest priority wins. Equal priorities go to the lowest vector.
- R6: The interrupt output is high only when the winning priority is strictly greater than the current-priority register (word 2 bits [3:0]). A source with priority 0 never interrupts. A current-priority write takes effect on the output two edges after the write edge.
- R7: Word 1 bit 0 selects hardware vector mode. When it is 1, the vector output carries the acknowledge vector. When it is 0, the vector output is zero, while the acknowledge register still updates.
- R8: Priorities sit in words 4 onward, eight 4-bit fields per word. Field j of word 4+w belongs to source 8w+j, where sources 0 to 7 are software and 8 onward are peripherals. Each field reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periphReq | input | NUM_PERIPH | Level request per peripheral input |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address for write and read |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irqOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 9 | Hardware vector (zero when the mode is off) |

## Verification
Each result has a fixed due cycle:

- **Peripheral request changes:** the interrupt output and vector are due three edges after the driving edge.
- **Software SET and CLR writes:** these act on the output four edges after the write edge.
- **Current-priority writes:** these act on the output two edges later.
- **Register readback:** this is combinational and is sampled in the same cycle.

The driver stamps each expected item with its due cycle (a free-running edge count plus the latency above) and pushes it into a queue. The monitor pops and compares each item on the falling edge of the cycle it is due. For rising cases, the bench also checks the cycle before the due cycle, so an early output is caught as well as a late one.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int BUS_DW = 32;
  localparam int SW_SRC = 8;
  localparam int VEC_W  = 9;
  localparam int PRIO_W = 4;
  localparam int FIELDS_PER_WORD = BUS_DW / PRIO_W;

  localparam int ADR_SW     = 0;
  localparam int ADR_CTRL   = 1;
  localparam int ADR_CURPRI = 2;
  localparam int ADR_ACK    = 3;
  localparam int ADR_PRI    = 4;

  typedef struct packed {
    logic              swWr;
    logic              ctrlWr;
    logic              curPriWr;
    logic              priWr;
    logic [7:0]        priIdx;
    logic [BUS_DW-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PRI_WORDS = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_DW-1:0] wrData,
  output regStrobe_t        strb
);
  localparam int PRI_END = ADR_PRI + PRI_WORDS;

  int addrInt;
  assign addrInt = int'(addr);

  always_comb begin
    strb      = '0;
    strb.data = wrData;
    if (wrEn) begin
      strb.swWr     = (addrInt == ADR_SW);
      strb.ctrlWr   = (addrInt == ADR_CTRL);
      strb.curPriWr = (addrInt == ADR_CURPRI);
      if (addrInt >= ADR_PRI && addrInt < PRI_END) begin
        strb.priWr  = 1'b1;
        strb.priIdx = 8'(addrInt - ADR_PRI);
      end
    end
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] pri,
  output logic                   winValid,
  output logic [PRIO_W-1:0]      winPri,
  output logic [VEC_W-1:0]       winVec
);
  // Ascending scan with a strict compare: equal priorities keep the
  // lower index, and priority 0 can never win.
  always_comb begin
    winValid = 1'b0;
    winPri   = '0;
    winVec   = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (req[s] && (pri[s*PRIO_W +: PRIO_W] > winPri)) begin
        winValid = 1'b1;
        winPri   = pri[s*PRIO_W +: PRIO_W];
        winVec   = VEC_W'(s);
      end
    end
  end
endmodule

// File: rtl/vpic_datapath.sv
module vpic_datapath
  import vpic_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [BUS_DW-1:0]     rdData,
  output logic                  irqOut,
  output logic [VEC_W-1:0]      vecOut
);
  localparam int NSRC = SW_SRC + NUM_PERIPH;

  logic [SW_SRC-1:0]        swFlag;
  logic                     hwMode;
  logic [PRIO_W-1:0]        curPri;
  logic [PRIO_W-1:0]        priArr [NSRC];
  logic [NSRC*PRIO_W-1:0]   priFlat;
  logic [NSRC-1:0]          reqStage;
  logic                     arbValid, arbValidQ;
  logic [PRIO_W-1:0]        arbPri, arbPriQ, irqPri;
  logic [VEC_W-1:0]         arbVec, arbVecQ, ackVec;
  logic [SW_SRC-1:0]        setMask, clrMask, setOnly;
  logic                     preempt;

  assign setMask = strb.data[SW_SRC-1:0];
  assign clrMask = strb.data[2*SW_SRC-1:SW_SRC];
  assign setOnly = setMask & ~clrMask;

  // Software flags: clear wins over set in the same write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          swFlag <= '0;
    else if (strb.swWr) swFlag <= (swFlag | setMask) & ~clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwMode <= 1'b0;
      curPri <= '0;
    end else begin
      if (strb.ctrlWr)   hwMode <= strb.data[0];
      if (strb.curPriWr) curPri <= strb.data[PRIO_W-1:0];
    end
  end

  // Per-source priority fields
  for (genvar s = 0; s < NSRC; s++) begin : g_pri
    localparam int WORD = s / FIELDS_PER_WORD;
    localparam int SLOT = s % FIELDS_PER_WORD;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        priArr[s] <= '0;
      else if (strb.priWr && strb.priIdx == 8'(WORD))
        priArr[s] <= strb.data[SLOT*PRIO_W +: PRIO_W];
    end
    assign priFlat[s*PRIO_W +: PRIO_W] = priArr[s];
  end

  // Stage 1: sample all requests (index equals vector number)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqStage <= '0;
    else       reqStage <= {periphReq, swFlag};
  end

  vpic_arbiter #(.NSRC(NSRC)) u_arb (
    .req      (reqStage),
    .pri      (priFlat),
    .winValid (arbValid),
    .winPri   (arbPri),
    .winVec   (arbVec)
  );

  // Stage 2: registered arbitration result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arbValidQ <= 1'b0;
      arbPriQ   <= '0;
      arbVecQ   <= '0;
    end else begin
      arbValidQ <= arbValid;
      arbPriQ   <= arbPri;
      arbVecQ   <= arbVec;
    end
  end

  // Stage 3: strict compare against current priority
  assign preempt = arbValidQ && (arbPriQ > curPri);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      irqPri <= '0;
      ackVec <= '0;
    end else begin
      irqOut <= preempt;
      irqPri <= arbPriQ;
      if (preempt) ackVec <= arbVecQ;
    end
  end

  assign vecOut = hwMode ? ackVec : '0;

  // Register readback
  int rdIdx;
  assign rdIdx = int'(rdAddr) - ADR_PRI;

  always_comb begin
    rdData = '0;
    case (int'(rdAddr))
      ADR_SW:     rdData[SW_SRC-1:0] = swFlag;
      ADR_CTRL:   rdData[0]          = hwMode;
      ADR_CURPRI: rdData[PRIO_W-1:0] = curPri;
      ADR_ACK:    rdData[VEC_W-1:0]  = ackVec;
      default: begin
        for (int s = 0; s < NSRC; s++) begin
          if (s / FIELDS_PER_WORD == rdIdx)
            rdData[(s % FIELDS_PER_WORD)*PRIO_W +: PRIO_W] = priArr[s];
        end
      end
    endcase
  end

  // Checks next to the logic they guard
  assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.swWr |=> ((swFlag & $past(setOnly)) == $past(setOnly)));

  assert_clr_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.swWr |=> ((swFlag & $past(clrMask)) == '0));

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.swWr |=> $stable(swFlag));

  assert_ack_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackVec < VEC_W'(NSRC));

  assert_win_needs_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    arbValid |-> (reqStage != '0));

  assert_irq_outranks_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqPri > $past(curPri)));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic                  irqOut,
  output logic [8:0]            vecOut
);
  localparam int NSRC      = SW_SRC + NUM_PERIPH;
  localparam int PRI_WORDS = (NSRC + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

  regStrobe_t strb;

  vpic_ctrl #(.ADDR_W(ADDR_W), .PRI_WORDS(PRI_WORDS)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb)
  );

  vpic_datapath #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .periphReq (periphReq),
    .rdAddr    (addr),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .vecOut    (vecOut)
  );
endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] periphReq = '0;
  logic          wrEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          irqOut;
  logic [8:0]    vecOut;

  vpic_top #(.NUM_PERIPH(NP), .ADDR_W(8)) dut (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut), .vecOut(vecOut)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    bit    irq;
    int    vec;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic expectAt(int due, bit irq, int vec, string tag);
    exp_t e;
    e.due = due; e.irq = irq; e.vec = vec; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare queued items when they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "irqOut", int'(irqOut), int'(e.irq));
      if (e.vec >= 0) chk(e.tag, "vecOut", int'(vecOut), e.vec);
    end
  end

  task automatic busWrite(int a, logic [31:0] d);
    wrEn = 1'b1; addr = 8'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(int a, output logic [31:0] v);
    addr = 8'(a);
    #1;
    v = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // Reset state
    chk("R1", "irqOut after reset", int'(irqOut), 0);
    chk("R7", "vecOut after reset", int'(vecOut), 0);
    readReg(0, v); chk("R3", "flags after reset", int'(v), 0);
    readReg(3, v); chk("R4", "ack after reset", int'(v), 0);

    // Setup: hardware vector mode on, priorities
    busWrite(1, 32'h1);
    busWrite(4, 32'h0030_0000);          // sw5 = 3
    busWrite(5, 32'h0000_5997);          // p0=7 p1=9 p2=9 p3=5 p4=0
    readReg(5, v); chk("R8", "priority word 5 readback", int'(v), 32'h5997);
    readReg(4, v); chk("R8", "priority word 4 readback", int'(v), 32'h0030_0000);
    idle(2);

    // R1/R4: peripheral 3 rises after three edges, vector 11
    k = cyc;
    expectAt(k + 2, 1'b0, -1, "R1 early");
    expectAt(k + 3, 1'b1, 11, "R1/R4 periph");
    periphReq[3] = 1'b1;
    idle(6);
    k = cyc;
    expectAt(k + 2, 1'b1, 11, "R1 hold");
    expectAt(k + 3, 1'b0, 11, "R1 level drop");
    periphReq = '0;
    idle(6);

    // R2/R4: software source 5, four edges, vector 5
    k = cyc;
    expectAt(k + 3, 1'b0, -1, "R2 early");
    expectAt(k + 4, 1'b1, 5, "R2/R4 sw");
    busWrite(0, 32'h0000_0020);
    idle(6);
    readReg(0, v); chk("R3", "flag 5 set", int'(v), 32'h20);
    k = cyc;
    expectAt(k + 3, 1'b1, 5, "R3 clr pending");
    expectAt(k + 4, 1'b0, 5, "R3 clr drop");
    busWrite(0, 32'h0000_2000);
    idle(6);

    // R3: set+clr together, zero write
    busWrite(0, 32'h0000_0404);
    readReg(0, v); chk("R3", "set+clr leaves clear", int'(v), 0);
    busWrite(0, 32'h0000_0004);
    readReg(0, v); chk("R3", "flag 2 set", int'(v), 32'h4);
    busWrite(0, 32'h0000_0000);
    readReg(0, v); chk("R3", "zero write no effect", int'(v), 32'h4);
    busWrite(0, 32'h0000_0400);
    readReg(0, v); chk("R3", "flag 2 cleared", int'(v), 0);
    idle(5);

    // R5: highest priority, then tie goes to lower vector
    k = cyc;
    expectAt(k + 3, 1'b1, 10, "R5 highest");
    periphReq = 16'h0005;
    idle(5);
    k = cyc;
    expectAt(k + 3, 1'b1, 9, "R5 tie lowest");
    periphReq = 16'h0007;
    idle(5);
    periphReq = '0;
    idle(5);

    // R6: strict compare against current priority
    busWrite(2, 32'h9);
    readReg(2, v); chk("R6", "current priority readback", int'(v), 9);
    idle(2);
    k = cyc;
    expectAt(k + 3, 1'b0, -1, "R6 equal blocked");
    expectAt(k + 4, 1'b0, -1, "R6 equal blocked");
    periphReq = 16'h0004;
    idle(6);
    k = cyc;
    expectAt(k + 1, 1'b0, -1, "R6 before lower");
    expectAt(k + 2, 1'b1, 10, "R6 lowered current");
    busWrite(2, 32'h8);
    idle(4);
    readReg(3, v); chk("R4", "ack vector 10", int'(v), 10);
    periphReq = '0;
    busWrite(2, 32'h0);
    idle(5);
    k = cyc;
    expectAt(k + 3, 1'b0, -1, "R6 priority zero");
    expectAt(k + 5, 1'b0, -1, "R6 priority zero");
    periphReq = 16'h0010;
    idle(7);
    periphReq = '0;
    idle(3);

    // R7: mode off -> vector output zero, ack still updates
    busWrite(1, 32'h0);
    idle(2);
    k = cyc;
    expectAt(k + 3, 1'b1, 0, "R7 mode off");
    periphReq = 16'h0008;
    idle(5);
    readReg(3, v); chk("R7", "ack updates with mode off", int'(v), 11);
    periphReq = '0;
    idle(5);

    finished = 1;
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    summary();
    $finish;
  end
endmodule